// File: doc/BRIEF.md
# Character Blink Timing Generator

This block decides, field by field, whether blinking characters of an on-screen text overlay are currently shown. It counts vertical sync pulses in a free-running field counter. From that count it derives a blink phase whose period and visible fraction are chosen by two small control inputs. All control state resets to zero.

For every character being drawn, the display pipeline presents that character's blink-enable bit, taken from its display-RAM word. The block answers with a foreground gate. A character without blink enabled is always shown. A character with blink enabled is shown only while the blink phase is in its visible part. Colour choice and the video path are handled elsewhere.

Top module: `blink_timing_gen`

## Requirements
- R1: After reset the field counter is zero, so `blink_on` is 1 for every duty code.
- R2: The field counter advances by exactly one for each rising edge of `vsync`. A `vsync` held high for several clocks counts once. The new count is visible at the outputs from the clock edge on which the rising level is first sampled.
- R3: With `period_sel`=0 the blink period is 64 fields. The phase quarter is field count bits [5:4], which is (count/16) mod 4.
- R4: With `period_sel`=1 the blink period is 32 fields. The phase quarter is field count bits [4:3], which is (count mod 32)/8.
- R5: With `duty_sel`=2'b01 the phase is visible (`blink_on`=1) only in quarter 0. This is 25% duty.
- R6: With `duty_sel`=2'b10 the phase is visible in quarters 0 and 1. This is 50% duty.
- R7: With `duty_sel`=2'b11 the phase is visible in quarters 0, 1 and 2. This is 75% duty.
- R8: The unused code `duty_sel`=2'b00 behaves exactly like 2'b10 (50%).
- R9: When `char_blink_en`=0, `fg_show` is 1 regardless of phase.
- R10: When `char_blink_en`=1, `fg_show` equals `blink_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync level, synchronous to clk |
| period_sel | input | 1 | 0: 64-field period, 1: 32-field period |
| duty_sel | input | 2 | 01: 25%, 10: 50%, 11: 75%, 00: 50% |
| char_blink_en | input | 1 | Blink-enable bit of the character being drawn |
| blink_on | output | 1 | 1 while the blink phase is in its visible part |
| fg_show | output | 1 | Foreground gate for the current character |

## Verification
The checker watches the field counter on every cycle. It confirms that the counter steps by one on each detected sync rise and stays put otherwise. It also confirms the 25% and 75% windows against the counter quarter, and the foreground gating for blinking and non-blinking characters. Only the bench's scenarios show the complete phase sequence across full 64- and 32-field periods, the wrap at the end of a period, the aliasing of the unused duty code to 50%, and that a long sync pulse counts once.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [1:0] {
        DUTY_ALIAS = 2'b00,
        DUTY_QTR   = 2'b01,
        DUTY_HALF  = 2'b10,
        DUTY_3QTR  = 2'b11
    } duty_e;

    function automatic logic [2:0] duty_limit(input logic [1:0] code);
        case (code)
            DUTY_QTR:  duty_limit = 3'd1;
            DUTY_3QTR: duty_limit = 3'd3;
            default:   duty_limit = 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/blink_vs_edge.sv
module blink_vs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic rise
);

    typedef struct packed {
        logic vs;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.vs = vsync;
        rise    = vsync & ~st_q.vs;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/blink_field_ctr.sv
module blink_field_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/blink_phase_cmp.sv
module blink_phase_cmp
    import blink_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] count,
    input  logic             period_sel,
    input  logic [1:0]       duty_sel,
    output logic             visible
);

    localparam int LONG_HI  = CNT_W - 1;
    localparam int SHORT_HI = CNT_W - 2;

    logic [1:0] qtr_long, qtr_short, qtr;

    assign qtr_long  = count[LONG_HI  -: 2];
    assign qtr_short = count[SHORT_HI -: 2];

    always_comb begin
        qtr     = period_sel ? qtr_short : qtr_long;
        visible = ({1'b0, qtr} < duty_limit(duty_sel));
    end

endmodule

// File: rtl/blink_timing_gen.sv
module blink_timing_gen #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync,
    input  logic       period_sel,
    input  logic [1:0] duty_sel,
    input  logic       char_blink_en,
    output logic       blink_on,
    output logic       fg_show
);

    logic             vs_rise;
    logic [CNT_W-1:0] field_cnt;

    blink_vs_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .vsync (vsync),
        .rise  (vs_rise)
    );

    blink_field_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (vs_rise),
        .count (field_cnt)
    );

    blink_phase_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count      (field_cnt),
        .period_sel (period_sel),
        .duty_sel   (duty_sel),
        .visible    (blink_on)
    );

    assign fg_show = ~char_blink_en | blink_on;

endmodule

// File: rtl/blink_timing_gen_chk.sv
module blink_timing_gen_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vs_rise,
    input logic [CNT_W-1:0] field_cnt,
    input logic             period_sel,
    input logic [1:0]       duty_sel,
    input logic             char_blink_en,
    input logic             blink_on,
    input logic             fg_show
);

    logic [1:0] q_chk;
    assign q_chk = period_sel ? field_cnt[CNT_W-2 -: 2] : field_cnt[CNT_W-1 -: 2];

    // R2: one step per detected rise
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> (field_cnt == CNT_W'($past(field_cnt) + 1'b1)));

    // R2: no step without a rise
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(field_cnt));

    // R5: 25% visible only in quarter 0
    a_r5_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sel == 2'b01) |-> (blink_on == (q_chk == 2'd0)));

    // R7: 75% hidden only in quarter 3
    a_r7_three_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sel == 2'b11) |-> (blink_on == (q_chk != 2'd3)));

    // R9: non-blinking characters always shown
    a_r9_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !char_blink_en |-> fg_show);

    // R10: blinking characters follow the phase
    a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
        char_blink_en |-> (fg_show == blink_on));

endmodule

bind blink_timing_gen blink_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vs_rise       (vs_rise),
    .field_cnt     (field_cnt),
    .period_sel    (period_sel),
    .duty_sel      (duty_sel),
    .char_blink_en (char_blink_en),
    .blink_on      (blink_on),
    .fg_show       (fg_show)
);

// File: tb/tb_blink_timing_gen.sv
module tb_blink_timing_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic       period_sel = 1'b0;
    logic [1:0] duty_sel = 2'b00;
    logic       char_blink_en = 1'b0;
    logic       blink_on, fg_show;

    int n_chk = 0;
    int n_bad = 0;
    int fields = 0;   // model of the field count since reset

    always #4 clk = ~clk;

    blink_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .period_sel(period_sel),
        .duty_sel(duty_sel), .char_blink_en(char_blink_en),
        .blink_on(blink_on), .fg_show(fg_show)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (field %0d, period %0b, duty %0b)",
                     req, got, exp, fields, period_sel, duty_sel);
        end
    endtask

    function automatic logic model_on(input int f, input logic ps, input logic [1:0] d);
        int q, lim;
        q   = ps ? ((f % 32) / 8) : ((f / 16) % 4);
        lim = (d == 2'b01) ? 1 : (d == 2'b11) ? 3 : 2;
        return q < lim;
    endfunction

    // one vsync pulse of given width; outputs settle after the first rising sample
    task automatic pulse(input int width);
        @(negedge clk) vsync = 1'b1;
        repeat (width) @(negedge clk);
        vsync = 1'b0;
        fields++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vsync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fields = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        for (int d = 0; d < 4; d++) begin
            duty_sel = 2'(d);
            #1 chk("R1", blink_on, 1'b1);
        end
    endtask

    // sweep a full period plus wrap, checking every field
    task automatic t_sweep(input logic ps, input logic [1:0] d, input string req);
        do_reset();
        period_sel = ps; duty_sel = d; char_blink_en = 1'b1;
        for (int i = 0; i < 72; i++) begin
            #1 chk(req, blink_on, model_on(fields, ps, d));
            chk("R10", fg_show, model_on(fields, ps, d));
            pulse(1);
        end
    endtask

    task automatic t_nonblink();
        do_reset();
        period_sel = 1'b0; duty_sel = 2'b01; char_blink_en = 1'b0;
        for (int i = 0; i < 64; i++) begin
            #1 chk("R9", fg_show, 1'b1);
            pulse(1);
        end
    endtask

    task automatic t_long_pulse();
        do_reset();
        period_sel = 1'b1; duty_sel = 2'b01; char_blink_en = 1'b1;
        for (int i = 0; i < 7; i++) pulse(1);
        #1 chk("R2", blink_on, 1'b1);   // field 7, quarter 0
        pulse(6);                       // held high: one count only
        #1 chk("R2", blink_on, 1'b0);   // field 8, quarter 1
        pulse(1);                       // field 9
        #1 chk("R2", blink_on, model_on(9, 1'b1, 2'b01));
    endtask

    initial begin
        t_reset();
        t_sweep(1'b0, 2'b10, "R3");
        t_sweep(1'b1, 2'b10, "R4");
        t_sweep(1'b0, 2'b01, "R5");
        t_sweep(1'b1, 2'b01, "R5");
        t_sweep(1'b0, 2'b10, "R6");
        t_sweep(1'b0, 2'b11, "R7");
        t_sweep(1'b1, 2'b11, "R7");
        t_sweep(1'b0, 2'b00, "R8");
        t_sweep(1'b1, 2'b00, "R8");
        t_nonblink();
        t_long_pulse();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule